// File: doc/BRIEF.md
# Predicate-Gated Store Buffer

This block holds stores between execution and the data cache when a core runs both sides of a hard-to-predict branch at once. A store may be tagged with a predicate identifier that names the side it was fetched on. Such a store stays in the buffer until a broadcast delivers the value of its predicate. If the value is true, the store leaves toward the cache in program order. If it is false, the store is dropped and memory is never written. A separate kill input, raised on a branch misprediction, empties the buffer and stops any request toward the cache in that cycle.

Loads probe the buffer combinationally for forwarding. The newest live store to the same address supplies the data, but only when doing so cannot carry a value from one unresolved path into another. An untagged store or a resolved-true store forwards to any load. A store whose predicate is still unknown forwards only to a load that carries the same predicate identifier. Any other match makes the load wait through the stall output, and the load is never forwarded speculatively.

Top module: `pred_store_buffer`

## Requirements
- R1: Out of reset the buffer is empty: dr_valid, ld_hit and ld_stall are 0 and alloc_ready is 1.
- R2: Stores leave through the drain port in allocation order. While dr_valid is 1 and dr_ready is 0, dr_valid, dr_addr and dr_data hold their values in the next cycle unless kill is raised.
- R3: The buffer holds DEPTH (8) stores. alloc_ready is 0 only when all of them are occupied, and an alloc_valid pulse while alloc_ready is 0 stores nothing.
- R4: A store with alloc_pred=1 is not offered on the drain port until a broadcast with pb_valid=1, pb_pid equal to its identifier and pb_value=1 has been seen. A broadcast in the same cycle as the store's allocation counts.
- R5: When the oldest store's predicate has resolved false, it leaves the buffer in one cycle with dr_valid held at 0, and the next store becomes the oldest.
- R6: kill=1 discards every buffered store, forces dr_valid to 0 in that cycle, and drops an allocation made in the same cycle.
- R7: A load with ld_valid=1 whose address matches takes ld_data from the youngest live matching store and raises ld_hit when that store is untagged or resolved true.
- R8: If that youngest match is tagged and unresolved, the load hits only when ld_pred=1 and ld_pid equals the store's identifier. Otherwise ld_stall=1 and ld_hit=0.
- R9: A store whose predicate resolved false never matches a load. The search continues to older stores.
- R10: With no live match, or with ld_valid=0, both ld_hit and ld_stall are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kill | input | 1 | Misprediction kill, empties the buffer |
| alloc_valid | input | 1 | New store to insert |
| alloc_addr | input | AW | Store address |
| alloc_data | input | DW | Store data |
| alloc_pred | input | 1 | Store is predicated |
| alloc_pid | input | PW | Predicate identifier of the store |
| alloc_ready | output | 1 | A free slot exists |
| pb_valid | input | 1 | Predicate broadcast valid |
| pb_pid | input | PW | Identifier being resolved |
| pb_value | input | 1 | Resolved predicate value |
| dr_valid | output | 1 | Oldest store offered to the cache |
| dr_addr | output | AW | Drain address |
| dr_data | output | DW | Drain data |
| dr_ready | input | 1 | Cache accepts the drain |
| ld_valid | input | 1 | Load lookup valid |
| ld_addr | input | AW | Load address |
| ld_pred | input | 1 | Load is on a predicated path |
| ld_pid | input | PW | Predicate identifier of the load |
| ld_hit | output | 1 | Forwarding permitted, ld_data valid |
| ld_data | output | DW | Forwarded data |
| ld_stall | output | 1 | Load must wait |

## Verification
On every cycle the assertions check that a stalled drain offer stays stable, that a kill leaves an empty buffer, that occupancy never exceeds capacity, and that a lookup never reports hit and stall together or answers with no load present. Whether a tagged store is actually held back until its own identifier resolves true, and whether the youngest-match and cross-path rules pick the right entry, depend on sequences of allocations, broadcasts and loads. Only the bench scenarios show these, by comparing against a reference queue.

// File: rtl/pred_store_buffer.sv
module pred_store_buffer #(
  parameter int DEPTH = 8,
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kill,
  input  logic          alloc_valid,
  input  logic [AW-1:0] alloc_addr,
  input  logic [DW-1:0] alloc_data,
  input  logic          alloc_pred,
  input  logic [PW-1:0] alloc_pid,
  output logic          alloc_ready,
  input  logic          pb_valid,
  input  logic [PW-1:0] pb_pid,
  input  logic          pb_value,
  output logic          dr_valid,
  output logic [AW-1:0] dr_addr,
  output logic [DW-1:0] dr_data,
  input  logic          dr_ready,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  input  logic          ld_pred,
  input  logic [PW-1:0] ld_pid,
  output logic          ld_hit,
  output logic [DW-1:0] ld_data,
  output logic          ld_stall
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = IW + 1;

  logic [AW-1:0] e_addr [DEPTH];
  logic [DW-1:0] e_data [DEPTH];
  logic [PW-1:0] e_pid  [DEPTH];
  logic [DEPTH-1:0] e_pr, e_rs, e_pv;
  logic [IW-1:0] head, tail;
  logic [CW-1:0] cnt;

  wire nonempty = cnt != '0;
  wire h_dead = e_pr[head] & e_rs[head] & ~e_pv[head];
  wire h_go = ~e_pr[head] | (e_rs[head] & e_pv[head]);
  wire pop = nonempty & ~kill & (h_dead | (h_go & dr_ready));
  wire push = alloc_valid & alloc_ready & ~kill;

  assign alloc_ready = cnt < CW'(DEPTH);
  assign dr_valid = nonempty & h_go & ~kill;
  assign dr_addr = e_addr[head];
  assign dr_data = e_data[head];

  always_comb begin
    logic [IW-1:0] idx;
    ld_hit = 1'b0;
    ld_stall = 1'b0;
    ld_data = '0;
    idx = head;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head + IW'(k);
      if (ld_valid && CW'(k) < cnt && e_addr[idx] == ld_addr &&
          !(e_pr[idx] && e_rs[idx] && !e_pv[idx])) begin
        if (!e_pr[idx] || e_rs[idx] || (ld_pred && ld_pid == e_pid[idx])) begin
          ld_hit = 1'b1;
          ld_stall = 1'b0;
          ld_data = e_data[idx];
        end else begin
          ld_hit = 1'b0;
          ld_stall = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      cnt <= '0;
      e_pr <= '0;
      e_rs <= '0;
      e_pv <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        e_addr[i] <= '0;
        e_data[i] <= '0;
        e_pid[i] <= '0;
      end
    end else if (kill) begin
      tail <= head;
      cnt <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (pb_valid && e_pr[i] && !e_rs[i] && e_pid[i] == pb_pid) begin
          e_rs[i] <= 1'b1;
          e_pv[i] <= pb_value;
        end
      if (push) begin
        e_addr[tail] <= alloc_addr;
        e_data[tail] <= alloc_data;
        e_pid[tail] <= alloc_pid;
        e_pr[tail] <= alloc_pred;
        e_rs[tail] <= alloc_pred && pb_valid && pb_pid == alloc_pid;
        e_pv[tail] <= pb_value;
        tail <= tail + 1'b1;
      end
      if (pop) head <= head + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/pred_store_buffer_chk.sv
module pred_store_buffer_chk #(
  parameter int DEPTH = 8,
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic clk,
  input logic rst_n,
  input logic kill,
  input logic alloc_ready,
  input logic dr_valid,
  input logic dr_ready,
  input logic [AW-1:0] dr_addr,
  input logic [DW-1:0] dr_data,
  input logic ld_valid,
  input logic ld_hit,
  input logic ld_stall,
  input logic [$clog2(DEPTH):0] cnt
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dr_valid && !dr_ready |=> kill || (dr_valid && $stable(dr_addr) && $stable(dr_data)));
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= ($clog2(DEPTH) + 1)'(DEPTH));
  p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> alloc_ready && !dr_valid && cnt == '0);
  p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_hit && ld_stall));
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |-> !ld_hit && !ld_stall);
endmodule

bind pred_store_buffer pred_store_buffer_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (.*);

// File: tb/pred_store_buffer_test.sv
`timescale 1ns/1ps
module pred_store_buffer_test;
  logic clk = 0, rst_n = 0, kill = 0;
  logic alloc_valid = 0, alloc_pred = 0, pb_valid = 0, pb_value = 0;
  logic dr_ready = 0, ld_valid = 0, ld_pred = 0;
  logic [15:0] alloc_addr = 0, ld_addr = 0;
  logic [31:0] alloc_data = 0;
  logic [2:0] alloc_pid = 0, pb_pid = 0, ld_pid = 0;
  logic alloc_ready, dr_valid, ld_hit, ld_stall;
  logic [15:0] dr_addr;
  logic [31:0] dr_data, ld_data;
  int checks = 0, errors = 0;

  typedef struct {logic [15:0] a; logic [31:0] d; bit pr; bit [2:0] pid; bit rs; bit pv;} ent_t;
  ent_t mq[$];

  always #2 clk = ~clk;

  pred_store_buffer uut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void ref_look(output bit hit, output bit stall, output logic [31:0] d);
    hit = 0; stall = 0; d = 0;
    if (!ld_valid) return;
    foreach (mq[i])
      if (mq[i].a == ld_addr && !(mq[i].pr && mq[i].rs && !mq[i].pv)) begin
        if (!mq[i].pr || mq[i].rs || (ld_pred && ld_pid == mq[i].pid)) begin
          hit = 1; stall = 0; d = mq[i].d;
        end else begin
          hit = 0; stall = 1;
        end
      end
  endfunction

  task automatic settle(); #0.5; endtask

  task automatic step();
    bit eh, es, go;
    logic [31:0] ed;
    int sz;
    ent_t n;
    sz = mq.size();
    chk("R3 alloc_ready", alloc_ready, sz < 8);
    go = sz > 0 && !kill && (!mq[0].pr || (mq[0].rs && mq[0].pv));
    chk("R4 dr_valid", dr_valid, go);
    if (go) begin
      chk("R2 dr_addr", dr_addr, mq[0].a);
      chk("R2 dr_data", dr_data, mq[0].d);
    end
    ref_look(eh, es, ed);
    chk("R7 ld_hit", ld_hit, eh);
    chk("R8 ld_stall", ld_stall, es);
    if (eh) chk("R7 ld_data", ld_data, ed);
    @(posedge clk);
    if (kill) mq.delete();
    else begin
      if (sz > 0 && ((mq[0].pr && mq[0].rs && !mq[0].pv) || (go && dr_ready))) void'(mq.pop_front());
      if (pb_valid)
        foreach (mq[i])
          if (mq[i].pr && !mq[i].rs && mq[i].pid == pb_pid) begin
            mq[i].rs = 1; mq[i].pv = pb_value;
          end
      if (alloc_valid && sz < 8) begin
        n.a = alloc_addr; n.d = alloc_data; n.pr = alloc_pred; n.pid = alloc_pid;
        n.rs = alloc_pred && pb_valid && pb_pid == alloc_pid; n.pv = pb_value;
        mq.push_back(n);
      end
    end
    @(negedge clk);
  endtask

  task automatic cyc(); settle(); step(); endtask

  task automatic idle();
    kill = 0; alloc_valid = 0; alloc_pred = 0; pb_valid = 0; ld_valid = 0; ld_pred = 0;
  endtask

  task automatic put(logic [15:0] a, logic [31:0] d, logic p, logic [2:0] id);
    alloc_valid = 1; alloc_addr = a; alloc_data = d; alloc_pred = p; alloc_pid = id;
  endtask

  task automatic load(logic [15:0] a, logic p, logic [2:0] id);
    ld_valid = 1; ld_addr = a; ld_pred = p; ld_pid = id;
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    load(16'h5, 0, 0);
    settle();
    chk("R1 dr_valid", dr_valid, 0);
    chk("R1 alloc_ready", alloc_ready, 1);
    chk("R10 ld_hit empty", ld_hit, 0);
    chk("R10 ld_stall empty", ld_stall, 0);
    step();

    idle(); dr_ready = 1;
    put(16'h10, 32'hA, 1, 2); cyc(); idle();
    repeat (3) begin settle(); chk("R4 held unresolved", dr_valid, 0); step(); end
    load(16'h10, 0, 0); settle(); chk("R8 untagged load stalls", ld_stall, 1); step();
    load(16'h10, 1, 2); settle(); chk("R8 same pid hits", ld_hit, 1); chk("R8 same pid data", ld_data, 32'hA); step();
    load(16'h10, 1, 3); settle(); chk("R8 other pid stalls", ld_stall, 1); step();
    idle(); pb_valid = 1; pb_pid = 2; pb_value = 0; cyc(); idle();
    load(16'h10, 0, 0); settle();
    chk("R9 dead no hit", ld_hit, 0); chk("R9 dead no stall", ld_stall, 0);
    chk("R5 no request for dead", dr_valid, 0); step(); idle();
    put(16'h20, 32'hB, 0, 0); cyc(); idle();
    settle(); chk("R5 next store at head", dr_addr, 16'h20); chk("R5 next valid", dr_valid, 1); step();

    dr_ready = 0;
    put(16'h30, 32'hC, 0, 0); cyc();
    put(16'h30, 32'hD, 1, 1); cyc(); idle();
    pb_valid = 1; pb_pid = 1; pb_value = 0; cyc(); idle();
    load(16'h30, 0, 0); settle(); chk("R9 older store forwards", ld_data, 32'hC); chk("R9 hit", ld_hit, 1); step();
    idle(); dr_ready = 1; repeat (3) cyc();
    put(16'h31, 32'hE, 1, 4); pb_valid = 1; pb_pid = 4; pb_value = 1; cyc(); idle();
    settle(); chk("R4 same-cycle resolve drains", dr_valid, 1); chk("R4 addr", dr_addr, 16'h31); step();

    dr_ready = 0;
    for (int i = 0; i < 8; i++) begin put(16'h200 + 16'(i), 32'(i), 0, 0); cyc(); end
    idle(); settle(); chk("R3 full", alloc_ready, 0); step();
    put(16'h99, 32'h99, 0, 0); cyc(); idle(); dr_ready = 1;
    for (int i = 0; i < 8; i++) begin settle(); chk("R2 order", dr_addr, 16'h200 + 16'(i)); step(); end
    settle(); chk("R3 overflow dropped", dr_valid, 0); step();

    dr_ready = 0;
    for (int i = 0; i < 3; i++) begin put(16'h300 + 16'(i), 32'(i), 0, 0); cyc(); end
    put(16'h3F, 32'h1, 0, 0); kill = 1; settle(); chk("R6 no drain in kill", dr_valid, 0); step(); idle();
    load(16'h300, 0, 0); settle();
    chk("R6 emptied no hit", ld_hit, 0); chk("R6 ready", alloc_ready, 1); chk("R6 no drain", dr_valid, 0); step();
    load(16'h3F, 0, 0); settle(); chk("R6 kill alloc dropped", ld_hit, 0); step(); idle();

    put(16'h40, 32'hE0, 0, 0); cyc();
    put(16'h40, 32'hF0, 0, 0); cyc(); idle();
    load(16'h40, 1, 5); settle(); chk("R7 youngest wins", ld_data, 32'hF0); step();
    idle(); dr_ready = 1; repeat (3) cyc();

    void'($urandom(32'd1234));
    for (int c = 0; c < 4000; c++) begin
      alloc_valid = ($urandom % 2) == 0;
      alloc_addr = 16'h100 + 16'($urandom % 4);
      alloc_data = $urandom;
      alloc_pred = ($urandom % 2) == 0;
      alloc_pid = 3'($urandom % 4);
      pb_valid = ($urandom % 5) == 0;
      pb_pid = 3'($urandom % 4);
      pb_value = ($urandom % 2) == 0;
      kill = ($urandom % 50) == 0;
      dr_ready = ($urandom % 5) < 3;
      ld_valid = ($urandom % 10) < 7;
      ld_addr = 16'h100 + 16'($urandom % 4);
      ld_pred = ($urandom % 2) == 0;
      ld_pid = 3'($urandom % 4);
      cyc();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule